// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that retires one instruction on every rising clock edge. It decodes a reduced load/store instruction set: word load, word store, five register-to-register operations (add, subtract, and, or, signed compare), branch-if-equal and an absolute jump. Instruction words arrive on a fetch port that is addressed by the program counter. Data accesses use a second, independent port, so a fetch and a data access can fall in the same cycle without contention.

Inside the core are the program counter, a 32-entry by 32-bit register file, the immediate sign extender, one ALU, a two-stage decoder and the next-PC selector. The first decode stage maps the opcode to a set of strobes and a 2-bit operation class. The second stage combines that class with the function field to pick a 4-bit ALU code. Both memory ports are combinational: the surrounding system returns the fetched word and the load data within the same cycle. Stores and register writes take effect at the clock edge that ends the instruction.

Top module: `core_top`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0. `imemAddr` always shows the PC. While `rst` is high, `dmemRead` and `dmemWrite` stay low and no register is written.
- R2: Opcode 35 (bits 31:26) loads a word. `dmemAddr` is register rs (bits 25:21) plus the sign-extended bits 15:0, and `dmemRead` is high. At the edge, register rt (bits 20:16) takes `dmemRdata`.
- R3: Opcode 43 stores a word. `dmemAddr` is rs plus the sign-extended bits 15:0, `dmemWrite` is high, `dmemWdata` carries register rt, and no register changes.
- R4: Opcode 0 writes register rd (bits 15:11) with rs op rt. The operation is selected by funct (bits 5:0): 32 add, 34 subtract, 36 and, 37 or. Both data strobes stay low.
- R5: Opcode 0 with funct 42 writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R6: Register 0 always reads as zero. A write that targets it has no effect.
- R7: Opcode 4 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by two. If they differ, the next PC is PC+4.
- R8: Opcode 2 sets the next PC to PC[31:28], then bits 25:0 of the instruction, then two zero bits.
- R9: Every instruction other than a taken branch or a jump advances the PC by 4.
- R10: Any opcode other than 0, 2, 4, 35 or 43 writes no register, keeps both data strobes low and advances the PC by 4.
- R11: `dmemRead` and `dmemWrite` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 32 | Fetch address (current PC) |
| imemData | input | 32 | Instruction word at `imemAddr`, same cycle |
| dmemAddr | output | 32 | Data access address |
| dmemWdata | output | 32 | Store data |
| dmemRdata | input | 32 | Load data at `dmemAddr`, same cycle |
| dmemRead | output | 1 | Load strobe |
| dmemWrite | output | 1 | Store strobe |

## Verification
The embedded properties assume that `imemData` and `dmemRdata` are fully defined whenever reset is low. They also assume that an opcode-0 word carries one of the five listed function codes, because no other function code has a defined result. The bench drives both inputs from tasks that only ever place complete, well-formed words on them. Every register-to-register vector uses one of the five function codes. Unsupported opcodes appear only as whole words whose register fields point at live registers, so an unwanted write would show up when those registers are read back through stores.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int XLEN      = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_AW    = $clog2(REG_COUNT);
  localparam int IMM_W     = 16;
  localparam int JIMM_W    = 26;

  typedef enum logic [5:0] {
    OP_RTYPE = 6'd0,
    OP_JUMP  = 6'd2,
    OP_BEQ   = 6'd4,
    OP_LOAD  = 6'd35,
    OP_STORE = 6'd43
  } opcode_e;

  typedef enum logic [1:0] {
    CLASS_ADD   = 2'b00,
    CLASS_SUB   = 2'b01,
    CLASS_FUNCT = 2'b10
  } opclass_e;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alufn_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic   regDst;
    logic   aluSrc;
    logic   memToReg;
    logic   regWrite;
    logic   memRead;
    logic   memWrite;
    logic   branch;
    logic   jump;
    alufn_e aluFn;
  } ctrl_t;

endpackage

// File: rtl/core_control.sv
module core_control
  import core_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  opclass_e opClass;
  ctrl_t    mainDec;

  // first level: opcode -> strobes and operation class
  always_comb begin
    mainDec       = '0;
    mainDec.aluFn = ALU_ADD;
    opClass       = CLASS_ADD;
    case (opcode)
      OP_RTYPE: begin
        mainDec.regDst   = 1'b1;
        mainDec.regWrite = 1'b1;
        opClass          = CLASS_FUNCT;
      end
      OP_LOAD: begin
        mainDec.aluSrc   = 1'b1;
        mainDec.memToReg = 1'b1;
        mainDec.regWrite = 1'b1;
        mainDec.memRead  = 1'b1;
      end
      OP_STORE: begin
        mainDec.aluSrc   = 1'b1;
        mainDec.memWrite = 1'b1;
      end
      OP_BEQ: begin
        mainDec.branch = 1'b1;
        opClass        = CLASS_SUB;
      end
      OP_JUMP: mainDec.jump = 1'b1;
      default: ;
    endcase
  end

  alufn_e aluSel;

  // second level: class refined by the function field
  always_comb begin
    case (opClass)
      CLASS_SUB:   aluSel = ALU_SUB;
      CLASS_FUNCT: begin
        case (funct)
          FN_SUB:  aluSel = ALU_SUB;
          FN_AND:  aluSel = ALU_AND;
          FN_OR:   aluSel = ALU_OR;
          FN_SLT:  aluSel = ALU_SLT;
          default: aluSel = ALU_ADD;
        endcase
      end
      default:     aluSel = ALU_ADD;
    endcase
  end

  always_comb begin
    ctrl       = mainDec;
    ctrl.aluFn = aluSel;
    if (rst) begin
      ctrl.regWrite = 1'b0;
      ctrl.memRead  = 1'b0;
      ctrl.memWrite = 1'b0;
      ctrl.branch   = 1'b0;
      ctrl.jump     = 1'b0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> (!ctrl.regWrite && !ctrl.memRead && !ctrl.memWrite));

  assert_unknown_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !(opcode inside {OP_RTYPE, OP_JUMP, OP_BEQ, OP_LOAD, OP_STORE})
      |-> (!ctrl.regWrite && !ctrl.memRead && !ctrl.memWrite && !ctrl.branch && !ctrl.jump));

  assert_port_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.memRead && ctrl.memWrite));

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rdAddrA,
  input  logic [AW-1:0]    rdAddrB,
  output logic [WIDTH-1:0] rdDataA,
  output logic [WIDTH-1:0] rdDataB,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData
);

  logic [WIDTH-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn && wrAddr != '0) regs[wrAddr] <= wrData;
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != '0) |=> (regs[$past(wrAddr)] == $past(wrData)));

  assert_zero_port_R6: assert property (@(posedge clk) disable iff (rst)
    (rdAddrB == '0) |-> (rdDataB == '0));

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alufn_e           fn,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  always_comb begin
    case (fn)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))};
      ALU_NOR: result = ~(opA | opB);
      default: result = opA + opB;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/core_datapath.sv
module core_datapath
  import core_pkg::*;
#(
  parameter int WIDTH   = XLEN,
  parameter int NREGS   = REG_COUNT,
  localparam int AW     = $clog2(NREGS),
  localparam int EXT_W  = WIDTH - IMM_W,
  localparam int PAGE_W = WIDTH - JIMM_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [WIDTH-1:0] instr,
  output logic [WIDTH-1:0] pc,
  output logic [WIDTH-1:0] dmemAddr,
  output logic [WIDTH-1:0] dmemWdata,
  input  logic [WIDTH-1:0] dmemRdata
);

  localparam logic [WIDTH-1:0] RESET_PC = '0;
  localparam logic [WIDTH-1:0] STEP     = WIDTH'(4);

  logic [AW-1:0]     rsIdx, rtIdx, rdIdx, wrIdx;
  logic [IMM_W-1:0]  imm;
  logic [JIMM_W-1:0] jumpImm;
  logic [WIDTH-1:0]  immExt, rsData, rtData, aluB, aluResult, wrData;
  logic [WIDTH-1:0]  pcPlus4, branchTarget, jumpTarget, nextPc;
  logic              aluZero, takeBranch;

  assign rsIdx   = instr[25:21];
  assign rtIdx   = instr[20:16];
  assign rdIdx   = instr[15:11];
  assign imm     = instr[IMM_W-1:0];
  assign jumpImm = instr[JIMM_W-1:0];
  assign immExt  = {{EXT_W{imm[IMM_W-1]}}, imm};

  assign wrIdx  = ctrl.regDst ? rdIdx : rtIdx;
  assign wrData = ctrl.memToReg ? dmemRdata : aluResult;

  core_regfile #(.WIDTH(WIDTH), .DEPTH(NREGS)) uRegs (
    .clk(clk), .rst(rst),
    .rdAddrA(rsIdx), .rdAddrB(rtIdx),
    .rdDataA(rsData), .rdDataB(rtData),
    .wrEn(ctrl.regWrite), .wrAddr(wrIdx), .wrData(wrData)
  );

  assign aluB = ctrl.aluSrc ? immExt : rtData;

  core_alu #(.WIDTH(WIDTH)) uAlu (
    .opA(rsData), .opB(aluB), .fn(ctrl.aluFn),
    .result(aluResult), .zero(aluZero)
  );

  assign dmemAddr  = aluResult;
  assign dmemWdata = rtData;

  assign pcPlus4      = pc + STEP;
  assign branchTarget = pcPlus4 + {immExt[WIDTH-3:0], 2'b00};
  assign jumpTarget   = {pc[WIDTH-1 -: PAGE_W], jumpImm, 2'b00};
  assign takeBranch   = ctrl.branch && aluZero;

  always_comb begin
    if (ctrl.jump)       nextPc = jumpTarget;
    else if (takeBranch) nextPc = branchTarget;
    else                 nextPc = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= nextPc;
  end

  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == RESET_PC));

  assert_seq_pc_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !ctrl.branch) |=> (pc == $past(pc) + STEP));

  assert_beq_equal_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && rsData == rtData) |=> (pc == $past(pc) + STEP + {$past(immExt[WIDTH-3:0]), 2'b00}));

  assert_beq_differ_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && rsData != rtData) |=> (pc == $past(pc) + STEP));

  assert_slt_bool_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl.aluFn == ALU_SLT) |-> (aluResult[WIDTH-1:1] == '0));

endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imemAddr,
  input  logic [31:0] imemData,
  output logic [31:0] dmemAddr,
  output logic [31:0] dmemWdata,
  input  logic [31:0] dmemRdata,
  output logic        dmemRead,
  output logic        dmemWrite
);

  ctrl_t ctrl;

  core_control uCtrl (
    .clk(clk), .rst(rst),
    .opcode(imemData[31:26]), .funct(imemData[5:0]),
    .ctrl(ctrl)
  );

  core_datapath #(.WIDTH(XLEN), .NREGS(REG_COUNT)) uPath (
    .clk(clk), .rst(rst), .ctrl(ctrl), .instr(imemData),
    .pc(imemAddr), .dmemAddr(dmemAddr), .dmemWdata(dmemWdata),
    .dmemRdata(dmemRdata)
  );

  assign dmemRead  = ctrl.memRead;
  assign dmemWrite = ctrl.memWrite;

endmodule

// File: tb/sim_core_top.sv
module sim_core_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic        dmemRead, dmemWrite;

  always #10 clk = ~clk;

  core_top u0 (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemRdata(dmemRdata),
    .dmemRead(dmemRead), .dmemWrite(dmemWrite)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] model [32];
  logic [31:0] expPc;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] rExpect(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20:   return a + b;
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic commonChecks();
    check("R9", "fetch address", imemAddr, expPc);
    check("R11", "read and write together", {31'd0, dmemRead & dmemWrite}, 32'd0);
  endtask

  task automatic doLoad(input int rt, input int rs, input logic [15:0] imm, input logic [31:0] value);
    imemData = encI(6'd35, rs, rt, imm);
    dmemRdata = value;
    #2;
    commonChecks();
    check("R2", "load strobe", {31'd0, dmemRead}, 32'd1);
    check("R2", "load address", dmemAddr, model[rs] + sext(imm));
    @(negedge clk);
    if (rt != 0) model[rt] = value;
    expPc = expPc + 4;
  endtask

  task automatic doStore(input int rt, input int rs, input logic [15:0] imm, input string req);
    imemData = encI(6'd43, rs, rt, imm);
    dmemRdata = 32'h5A5A_5A5A;
    #2;
    commonChecks();
    check("R3", "store strobe", {31'd0, dmemWrite}, 32'd1);
    check("R3", "store address", dmemAddr, model[rs] + sext(imm));
    check(req, "store data", dmemWdata, model[rt]);
    @(negedge clk);
    expPc = expPc + 4;
  endtask

  task automatic doR(input int rd, input int rs, input int rt, input logic [5:0] fn);
    imemData = encR(rs, rt, rd, fn);
    dmemRdata = 32'hFFFF_0000;
    #2;
    commonChecks();
    check("R4", "strobes on ALU op", {30'd0, dmemRead, dmemWrite}, 32'd0);
    @(negedge clk);
    if (rd != 0) model[rd] = rExpect(fn, model[rs], model[rt]);
    expPc = expPc + 4;
  endtask

  task automatic doBeq(input int rs, input int rt, input logic [15:0] imm);
    imemData = encI(6'd4, rs, rt, imm);
    #2;
    commonChecks();
    check("R7", "strobes on branch", {30'd0, dmemRead, dmemWrite}, 32'd0);
    @(negedge clk);
    if (model[rs] == model[rt]) expPc = expPc + 4 + {sext(imm)[29:0], 2'b00};
    else expPc = expPc + 4;
    #2;
    check("R7", "branch next pc", imemAddr, expPc);
  endtask

  task automatic doJump(input logic [25:0] target);
    imemData = {6'd2, target};
    #2;
    commonChecks();
    check("R8", "strobes on jump", {30'd0, dmemRead, dmemWrite}, 32'd0);
    @(negedge clk);
    expPc = {expPc[31:28], target, 2'b00};
    #2;
    check("R8", "jump next pc", imemAddr, expPc);
  endtask

  task automatic doRaw(input logic [31:0] word);
    imemData = word;
    dmemRdata = 32'h1234_5678;
    #2;
    commonChecks();
    check("R10", "strobes on unsupported", {30'd0, dmemRead, dmemWrite}, 32'd0);
    @(negedge clk);
    expPc = expPc + 4;
    #2;
    check("R10", "pc after unsupported", imemAddr, expPc);
  endtask

  function automatic logic [31:0] seedVal(input int r);
    case (r)
      1: return 32'h0000_0000;
      2: return 32'h0000_0001;
      3: return 32'hFFFF_FFFF;
      4: return 32'h7FFF_FFFF;
      5: return 32'h8000_0000;
      6: return 32'h0000_0001;
      7: return 32'hFFFF_FFFE;
      8: return 32'h1234_5678;
      default: return 32'(r) * 32'h9E37_79B9 ^ 32'h0F0F_00FF;
    endcase
  endfunction

  bit finished = 1'b0;

  initial begin
    #(20 * 200000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    rst = 1'b1;
    imemData = encI(6'd43, 0, 1, 16'h0010);
    dmemRdata = 32'd0;
    repeat (3) @(negedge clk);
    #2;
    check("R1", "pc under reset", imemAddr, 32'd0);
    check("R1", "strobes under reset", {30'd0, dmemRead, dmemWrite}, 32'd0);
    imemData = encI(6'd35, 0, 9, 16'h0020);
    #2;
    check("R1", "load strobe under reset", {31'd0, dmemRead}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    expPc = 32'd0;

    // fill registers through loads
    for (int r = 1; r < 32; r++) doLoad(r, 0, 16'(4 * r), seedVal(r));
    // read back, negative offset exercises sign extension
    for (int r = 1; r < 32; r++) doStore(r, 0, 16'hFFFC, "R2");
    doLoad(9, 3, 16'h0008, 32'hCAFE_F00D);
    doStore(9, 5, 16'h8000, "R2");

    // register zero
    doLoad(0, 0, 16'h0040, 32'hDEAD_BEEF);
    doStore(0, 0, 16'h0000, "R6");
    doR(0, 3, 4, 6'h20);
    doStore(0, 4, 16'h0004, "R6");
    doR(21, 0, 3, 6'h25);
    doStore(21, 0, 16'h0000, "R6");

    // register-to-register sweep
    for (int f = 0; f < 5; f++) begin
      logic [5:0] fn;
      fn = (f == 0) ? 6'h20 : (f == 1) ? 6'h22 : (f == 2) ? 6'h24 : (f == 3) ? 6'h25 : 6'h2A;
      for (int a = 1; a <= 8; a++) begin
        for (int b = 1; b <= 8; b++) begin
          doR(20, a, b, fn);
          doStore(20, 0, 16'h0100, (fn == 6'h2A) ? "R5" : "R4");
        end
      end
    end

    // branches, taken and not taken
    doBeq(2, 6, 16'h0005);
    doBeq(1, 2, 16'h0005);
    doBeq(3, 3, 16'hFFFD);
    doBeq(4, 5, 16'hFFF0);
    doBeq(0, 1, 16'h7FFF);
    doBeq(3, 7, 16'h0002);
    doR(22, 5, 4, 6'h2A);
    doStore(22, 0, 16'h0000, "R5");

    // unsupported opcodes, register fields pointing at live registers
    doRaw(encI(6'd8, 0, 5, 16'h1234));
    doRaw(encI(6'd13, 3, 6, 16'hFFFF));
    doRaw(encI(6'd15, 0, 7, 16'h8000));
    doRaw(encI(6'd63, 4, 8, 16'h0001));
    for (int r = 5; r <= 8; r++) doStore(r, 0, 16'h0000, "R10");

    // jumps, including one whose upper PC bits are nonzero
    doJump(26'h000_0123);
    doJump(26'h3FF_FFFF);
    doStore(8, 0, 16'h0000, "R9");
    doJump(26'h000_0010);
    check("R8", "page bits kept", {28'd0, imemAddr[31:28]}, 32'd1);
    doStore(4, 0, 16'h0000, "R9");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule